// File: doc/BRIEF.md
# Fixed-Priority DMA Channel Arbiter

This block decides which of four DMA channels owns the system bus. Channel 0 serves periodic dynamic-memory refresh and is requested by a one-clock refresh tick. Channels 1 to 3 are requested by peripherals through level-sensitive, active-high lines that are asynchronous to the bus clock. A peripheral keeps its line high until it sees its acknowledge go low, then releases it.

Only one channel is granted at a time. A grant is a transfer cycle of a fixed number of clocks (four by default). During that cycle the channel's active-low acknowledge is driven low and the address-enable output is driven high, which takes the bus away from the processor. At least one idle clock follows each transfer cycle before the next arbitration.

Each channel has a transfer counter that software loads with a value V. The channel's (V+1)-th transfer is terminal. During that transfer the block pulses its terminal-count output, and the counter then reloads V on its own. Generating addresses and read/write strobes is left to other logic.

Top module: `dma_arbiter`

## Requirements
- R1: While reset is high and on the first clock after reset, all four acknowledges are high (inactive), address enable is low and terminal count is low. Every channel counter resets to 0.
- R2: Peripheral channel k (k = 1..3) is requested on `dreq_i[k-1]`. From an idle arbiter, a request that rises before clock edge n shows acknowledge `dack_n_o[k]` low after edge n+2. It does not show it earlier.
- R3: Peripheral channels are ranked in fixed order: channel 1 first, then 2, then 3. When several requests are pending at arbitration, the lowest-numbered channel wins.
- R4: The refresh channel (acknowledge `dack_n_o[0]`) outranks every peripheral. A refresh tick sampled on an edge while the arbiter is idle is granted on that same edge. A tick that arrives during another grant is remembered and served at the next arbitration.
- R5: A grant keeps one acknowledge low and address enable high for exactly XFER_CYCLES consecutive clocks. It is followed by at least one clock with all acknowledges high and address enable low. Address enable is high exactly when some acknowledge is low.
- R6: At most one acknowledge is low in any clock.
- R7: Pulsing `cnt_load_i[c]` loads `cnt_value_i` = V into channel c. The channel's (V+1)-th transfer after the load raises terminal count for exactly one clock, the last clock of that transfer. The count then reloads V, and the next V transfers give no terminal count. With count 0, every transfer is terminal.
- R8: Requests are level-sensitive. A request line that goes high and falls again within one clock while another channel is granted is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dreq_i | input | 3 | Asynchronous peripheral requests, bit k-1 for channel k |
| refresh_tick_i | input | 1 | One-clock synchronous refresh request for channel 0 |
| cnt_load_i | input | 4 | Per-channel count load strobe, bit c for channel c |
| cnt_value_i | input | CNT_W | Transfer count value V taken by a load |
| dack_n_o | output | 4 | Active-low acknowledges, bit c for channel c |
| aen_o | output | 1 | Address enable, high while a DMA channel owns the bus |
| tc_o | output | 1 | Terminal-count pulse, active high |

## Verification
A peripheral request passes through two synchronizer flops and one grant register. Its acknowledge therefore becomes due after the third rising edge following the input change. A refresh tick is seen on the edge that samples it, so its acknowledge is due after one edge. The bench drives every input on the falling edge and counts rising edges from that point. It checks that nothing appears early and that the result is present at the exact falling edge where it is due. Transfer length, the idle gap and the position of the terminal-count pulse are counted in samples at falling edges from the first low acknowledge sample. The model requester releases its line on the first sample that shows its acknowledge. The bench computes the next winner and the transfer that carries terminal count from the requirement rules alone.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int PERIPH_CH   = 3;
    localparam int TOTAL_CH    = PERIPH_CH + 1;
    localparam int CH_IDX_W    = $clog2(TOTAL_CH);
    localparam int REFRESH_IDX = 0;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_XFER = 1'b1
    } arb_state_e;

    typedef struct packed {
        arb_state_e             st;
        logic [CH_IDX_W-1:0]    chan;
    } grant_t;

    function automatic logic [TOTAL_CH-1:0] chan_onehot(input logic [CH_IDX_W-1:0] idx);
        logic [TOTAL_CH-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // lowest index wins: scan from the top so the last hit is the lowest
    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    input  logic             step_i,
    output logic             last_o
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            base_q <= value_i;
            left_q <= value_i;
        end else if (step_i) begin
            left_q <= (left_q == '0) ? base_q : left_q - CNT_W'(1);
        end
    end

    assign last_o = (left_q == '0);
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dma_arb_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int XFER_CYCLES = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [PERIPH_CH-1:0] dreq_i,
    input  logic                 refresh_tick_i,
    input  logic [TOTAL_CH-1:0]  cnt_load_i,
    input  logic [CNT_W-1:0]     cnt_value_i,
    output logic [TOTAL_CH-1:0]  dack_n_o,
    output logic                 aen_o,
    output logic                 tc_o
);
    localparam int BEAT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(XFER_CYCLES - 1);

    logic [PERIPH_CH-1:0] req_s;
    logic [TOTAL_CH-1:0]  cand;
    logic                 cand_any;
    logic [CH_IDX_W-1:0]  win_idx;
    logic                 refresh_pend_q;
    grant_t               g_q;
    logic [BEAT_W-1:0]    beat_q;
    logic                 start;
    logic                 xfer_end;
    logic [TOTAL_CH-1:0]  ch_last;

    dma_req_sync #(.W(PERIPH_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (dreq_i),
        .sync_o  (req_s)
    );

    assign cand = {req_s, refresh_pend_q | refresh_tick_i};

    dma_prio_pick #(.N(TOTAL_CH), .IW(CH_IDX_W)) u_pick (
        .cand_i (cand),
        .any_o  (cand_any),
        .idx_o  (win_idx)
    );

    assign start    = (g_q.st == ARB_IDLE) && cand_any;
    assign xfer_end = (g_q.st == ARB_XFER) && (beat_q == LAST_BEAT);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            refresh_pend_q <= 1'b0;
        end else begin
            refresh_pend_q <= (refresh_pend_q | refresh_tick_i)
                              & ~(start && (win_idx == CH_IDX_W'(REFRESH_IDX)));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            g_q.st   <= ARB_IDLE;
            g_q.chan <= '0;
            beat_q   <= '0;
        end else begin
            unique case (g_q.st)
                ARB_IDLE: begin
                    if (cand_any) begin
                        g_q.st   <= ARB_XFER;
                        g_q.chan <= win_idx;
                        beat_q   <= '0;
                    end
                end
                ARB_XFER: begin
                    if (beat_q == LAST_BEAT) begin
                        g_q.st <= ARB_IDLE;
                    end else begin
                        beat_q <= beat_q + BEAT_W'(1);
                    end
                end
                default: g_q.st <= ARB_IDLE;
            endcase
        end
    end

    for (genvar c = 0; c < TOTAL_CH; c++) begin : g_cnt
        dma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .load_i  (cnt_load_i[c]),
            .value_i (cnt_value_i),
            .step_i  (xfer_end && (g_q.chan == CH_IDX_W'(c))),
            .last_o  (ch_last[c])
        );
    end

    assign dack_n_o = (g_q.st == ARB_XFER) ? ~chan_onehot(g_q.chan) : '1;
    assign aen_o    = (g_q.st == ARB_XFER);
    assign tc_o     = xfer_end && ch_last[g_q.chan];
endmodule

// File: rtl/dma_arbiter_chk.sv
module dma_arbiter_chk #(
    parameter int XFER_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] dack_n,
    input logic       aen,
    input logic       tc
);
    localparam int RUN_W = $clog2(XFER_CYCLES + 2) + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)      run_q <= '0;
        else if (aen) run_q <= run_q + RUN_W'(1);
        else          run_q <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (dack_n == 4'hF && !aen && !tc));

    p_one_ack_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    p_aen_tracks_ack_r5: assert property (@(posedge clk) disable iff (rst)
        aen == (dack_n != 4'hF));

    p_ack_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (aen && $past(aen)) |-> $stable(dack_n));

    p_xfer_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(aen) |-> (run_q == RUN_W'(XFER_CYCLES)));

    p_tc_last_beat_r7: assert property (@(posedge clk) disable iff (rst)
        tc |-> (aen && run_q == RUN_W'(XFER_CYCLES - 1)));

    p_tc_single_r7: assert property (@(posedge clk) disable iff (rst)
        tc |=> (!tc && !aen));
endmodule

bind dma_arbiter dma_arbiter_chk #(.XFER_CYCLES(XFER_CYCLES)) u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .dack_n (dack_n_o),
    .aen    (aen_o),
    .tc     (tc_o)
);

// File: tb/dma_arbiter_tb.sv
module dma_arbiter_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       dreq = '0;
    logic             tick = 1'b0;
    logic [3:0]       cnt_load = '0;
    logic [CNT_W-1:0] cnt_value = '0;
    logic [3:0]       dack_n;
    logic             aen;
    logic             tc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    dma_arbiter #(.CNT_W(CNT_W)) u_dut (
        .clk_i          (clk),
        .rst_i          (rst),
        .dreq_i         (dreq),
        .refresh_tick_i (tick),
        .cnt_load_i     (cnt_load),
        .cnt_value_i    (cnt_value),
        .dack_n_o       (dack_n),
        .aen_o          (aen),
        .tc_o           (tc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // called at a falling edge; waits for a grant, follows it to its end
    task automatic observe_grant(input int exp_ch, input bit drop,
                                 input bit tc_last, input string req);
        int waited = 0;
        int low = 0;
        int tcs = 0;
        int tc_at = -1;
        int got = -1;
        while (dack_n == 4'hF && waited < 30) begin
            @(negedge clk);
            waited++;
        end
        for (int c = 0; c < 4; c++) if (!dack_n[c]) got = c;
        check(got == exp_ch, req, "granted channel", got, exp_ch);
        if (drop && exp_ch > 0) dreq[exp_ch-1] = 1'b0;
        while (dack_n != 4'hF && low < 10) begin
            low++;
            check(aen == 1'b1, "R5", "aen during grant", aen, 1);
            if (tc) begin
                tcs++;
                tc_at = low;
            end
            @(negedge clk);
        end
        check(low == 4, "R5", "grant length", low, 4);
        check(aen == 1'b0, "R5", "aen in gap", aen, 0);
        check(tcs == (tc_last ? 1 : 0), "R7", "tc pulses in transfer", tcs, tc_last ? 1 : 0);
        if (tc_last) check(tc_at == 4, "R7", "tc position", tc_at, 4);
    endtask

    task automatic settle();
        dreq = '0;
        tick = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        check(dack_n == 4'hF, "R1", "dack in reset", dack_n, 15);
        check(aen == 1'b0, "R1", "aen in reset", aen, 0);
        rst = 1'b0;
        @(negedge clk);
        check(dack_n == 4'hF && !aen && !tc, "R1", "idle after reset",
              {tc, aen, dack_n}, 15);
    endtask

    task automatic t_latency();
        dreq[1] = 1'b1;
        @(negedge clk);
        check(dack_n == 4'hF, "R2", "no ack after 1 edge", dack_n, 15);
        @(negedge clk);
        check(dack_n == 4'hF, "R2", "no ack after 2 edges", dack_n, 15);
        @(negedge clk);
        check(dack_n == 4'b1011, "R2", "ack after 3 edges", dack_n, 11);
        observe_grant(2, 1, 1, "R2");
        repeat (5) @(negedge clk);
        check(dack_n == 4'hF, "R2", "released request not regranted", dack_n, 15);
        settle();
    endtask

    task automatic t_priority();
        dreq = 3'b111;
        observe_grant(1, 1, 1, "R3");
        observe_grant(2, 1, 1, "R3");
        observe_grant(3, 1, 1, "R3");
        settle();
    endtask

    task automatic t_refresh();
        dreq[0] = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(dack_n == 4'b1110, "R4", "refresh ack after 1 edge", dack_n, 14);
        observe_grant(0, 0, 1, "R4");
        observe_grant(1, 1, 1, "R4");
        settle();
        dreq = 3'b110;
        repeat (3) @(negedge clk);
        fork
            observe_grant(2, 1, 1, "R4");
            begin
                @(negedge clk);
                tick = 1'b1;
                @(negedge clk);
                tick = 1'b0;
            end
        join
        observe_grant(0, 0, 1, "R4");
        observe_grant(3, 1, 1, "R4");
        settle();
    endtask

    task automatic t_level();
        int stray = 0;
        dreq[0] = 1'b1;
        repeat (3) @(negedge clk);
        dreq[1] = 1'b1;
        fork
            observe_grant(1, 1, 1, "R8");
            begin
                @(negedge clk);
                dreq[1] = 1'b0;
            end
        join
        for (int i = 0; i < 10; i++) begin
            if (dack_n != 4'hF) stray++;
            @(negedge clk);
        end
        check(stray == 0, "R8", "short pulse granted", stray, 0);
        settle();
    endtask

    task automatic t_count();
        cnt_value = 8'd2;
        cnt_load  = 4'b1000;
        @(negedge clk);
        cnt_load  = '0;
        dreq[2] = 1'b1;
        observe_grant(3, 0, 0, "R7");
        observe_grant(3, 0, 0, "R7");
        observe_grant(3, 0, 1, "R7");
        observe_grant(3, 0, 0, "R7");
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_priority();
        t_refresh();
        t_level();
        t_count();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            report();
        end
    end
endmodule